// File: doc/BRIEF.md
# Presence-Triggered Instruction Template Engine

This block keeps a small table of instruction templates and runs them in data-driven order. Each template holds an operation code, two destination codes and two operand slots (left and right), each slot with a presence bit. A token arriving on the input port names a template, selects the left or right slot and carries a value. A template runs only when both slots are filled. The engine then computes one integer result, clears both presence bits and sends the result once to each destination the template names. A destination is either another template slot inside the table or the external output port.

A host write port loads the operation code and destinations of one template and empties its slots. Results addressed to internal templates go into a small pending queue. The engine drains that queue before it takes any new input token, so a dataflow graph loaded into the table runs to completion by itself. At most one token, internal or external, is handled per cycle. The control is a three-state machine. `ST_IDLE` takes one token. A token that completes a template moves the machine to `ST_EMIT1`, which delivers the result to destination 1. `ST_EMIT2` then delivers it to destination 2. The machine moves from `ST_EMIT1` to `ST_EMIT2`, and from `ST_EMIT2` back to `ST_IDLE`, once its delivery is done. A delivery is done at once for "none" and internal destinations, and on the output handshake for the external destination.

Top module: `dfs_tpl_engine`

## Requirements
- R1: After reset, out_valid and err_ovf are 0, in_ready is 1, and every operand slot is empty.
- R2: A host write (host_we=1) stores host_opc, host_dst1 and host_dst2 into template host_addr and empties both of its slots. in_ready is 0 in that cycle.
- R3: A token fills its slot (in_port 0 = left, 1 = right) with in_data. A template whose other slot is still empty produces no output.
- R4: A token that reaches an already filled slot is dropped and the stored value is kept. err_ovf is 1 for exactly the one cycle after that token is taken.
- R5: A token that fills the second slot fires the template. Both slots are emptied, and the result wraps modulo 2^DATA_W. The opcodes are 0 add (L+R), 1 subtract (L-R), 2 multiply by MUL_K (L*MUL_K) and 3 pass (L).
- R6: Destination codes are DEST_W = IDX_W+2 bits wide. All ones means none. Top bit 1 (other than all ones) means the external port. Top bit 0 means internal, with bits [IDX_W:1] the template and bit 0 the side (0 left, 1 right).
- R7: A firing emits one token per destination that is not none, destination 1 before destination 2. Two "none" destinations emit nothing.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged.
- R9: Results sent to internal destinations are handled as tokens before any new input token. in_ready is 0 while such a token is pending.
- R10: in_ready is 0 while a firing is being delivered (out_valid=1 or an emit state).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Template load strobe |
| host_addr | input | IDX_W | Template to load |
| host_opc | input | 2 | Operation code |
| host_dst1 | input | DEST_W | First destination code |
| host_dst2 | input | DEST_W | Second destination code |
| in_valid | input | 1 | Input token valid |
| in_ready | output | 1 | Input token accepted this cycle when valid |
| in_addr | input | IDX_W | Target template |
| in_port | input | 1 | Target slot, 0 left, 1 right |
| in_data | input | DATA_W | Token value |
| out_valid | output | 1 | External result valid |
| out_ready | input | 1 | External result taken |
| out_data | output | DATA_W | External result value |
| err_ovf | output | 1 | One-cycle pulse for a dropped token |

## Verification
The hardest case to reach from the ports is a chain: a result fed back into the table, filling a template that then fires from the pending queue while the input port is held off. Directed tests load small acyclic graphs whose destinations point at other templates. They then check that the final external value equals the composed arithmetic. An internal token that hits a filled slot must also raise the overflow pulse. Random templates that drive only external or "none" destinations are then driven by random tokens, and a reference model tracks the fill state of every slot.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MULK = 2'd2,
        OP_PASS = 2'd3
    } dfs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EMIT1 = 2'd1,
        ST_EMIT2 = 2'd2
    } dfs_state_e;

endpackage

// File: rtl/dfs_alu.sv
module dfs_alu #(
    parameter int DATA_W = 16,
    parameter int MUL_K  = 3
) (
    input  dfs_pkg::dfs_op_e    opc,
    input  logic [DATA_W-1:0]   lhs,
    input  logic [DATA_W-1:0]   rhs,
    output logic [DATA_W-1:0]   res
);
    localparam logic [DATA_W-1:0] KVAL = DATA_W'(MUL_K);

    always_comb begin
        unique case (opc)
            dfs_pkg::OP_ADD:  res = lhs + rhs;
            dfs_pkg::OP_SUB:  res = lhs - rhs;
            dfs_pkg::OP_MULK: res = lhs * KVAL;
            dfs_pkg::OP_PASS: res = lhs;
            default:          res = lhs;
        endcase
    end
endmodule

// File: rtl/dfs_tok_fifo.sv
module dfs_tok_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + CNT_W'(1);
            else if (pop && !push) count <= count - CNT_W'(1);
        end
    end

    assign dout = slots[rd_ptr];
endmodule

// File: rtl/dfs_tpl_store.sv
module dfs_tpl_store #(
    parameter int N_TPL  = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16,
    parameter int DEST_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [IDX_W-1:0]     host_addr,
    input  dfs_pkg::dfs_op_e     host_opc,
    input  logic [DEST_W-1:0]    host_d1,
    input  logic [DEST_W-1:0]    host_d2,
    input  logic                 set_we,
    input  logic [IDX_W-1:0]     set_addr,
    input  logic                 set_port,
    input  logic [DATA_W-1:0]    set_data,
    input  logic                 clr_we,
    input  logic [IDX_W-1:0]     clr_addr,
    input  logic [IDX_W-1:0]     rd_addr,
    output dfs_pkg::dfs_op_e     rd_opc,
    output logic [DEST_W-1:0]    rd_d1,
    output logic [DEST_W-1:0]    rd_d2,
    output logic [DATA_W-1:0]    rd_vl,
    output logic [DATA_W-1:0]    rd_vr,
    output logic                 rd_pl,
    output logic                 rd_pr
);
    dfs_pkg::dfs_op_e  opc_a [N_TPL];
    logic [DEST_W-1:0] d1_a  [N_TPL];
    logic [DEST_W-1:0] d2_a  [N_TPL];
    logic [DATA_W-1:0] vl_a  [N_TPL];
    logic [DATA_W-1:0] vr_a  [N_TPL];
    logic [N_TPL-1:0]  pl_a, pr_a;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TPL; i++) begin
                opc_a[i] <= dfs_pkg::OP_ADD;
                d1_a[i]  <= '1;
                d2_a[i]  <= '1;
                vl_a[i]  <= '0;
                vr_a[i]  <= '0;
            end
            pl_a <= '0;
            pr_a <= '0;
        end else begin
            for (int i = 0; i < N_TPL; i++) begin
                if (host_we && host_addr == IDX_W'(i)) begin
                    opc_a[i] <= host_opc;
                    d1_a[i]  <= host_d1;
                    d2_a[i]  <= host_d2;
                    pl_a[i]  <= 1'b0;
                    pr_a[i]  <= 1'b0;
                end else begin
                    if (clr_we && clr_addr == IDX_W'(i)) begin
                        pl_a[i] <= 1'b0;
                        pr_a[i] <= 1'b0;
                    end
                    if (set_we && set_addr == IDX_W'(i)) begin
                        if (set_port) begin
                            pr_a[i] <= 1'b1;
                            vr_a[i] <= set_data;
                        end else begin
                            pl_a[i] <= 1'b1;
                            vl_a[i] <= set_data;
                        end
                    end
                end
            end
        end
    end

    assign rd_opc = opc_a[rd_addr];
    assign rd_d1  = d1_a[rd_addr];
    assign rd_d2  = d2_a[rd_addr];
    assign rd_vl  = vl_a[rd_addr];
    assign rd_vr  = vr_a[rd_addr];
    assign rd_pl  = pl_a[rd_addr];
    assign rd_pr  = pr_a[rd_addr];
endmodule

// File: rtl/dfs_tpl_engine.sv
module dfs_tpl_engine #(
    parameter int N_TPL      = 8,
    parameter int DATA_W     = 16,
    parameter int MUL_K      = 3,
    parameter int FIFO_DEPTH = 4,
    localparam int IDX_W     = (N_TPL > 1) ? $clog2(N_TPL) : 1,
    localparam int DEST_W    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [1:0]        host_opc,
    input  logic [DEST_W-1:0] host_dst1,
    input  logic [DEST_W-1:0] host_dst2,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_addr,
    input  logic              in_port,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              err_ovf
);
    import dfs_pkg::*;

    localparam int TOK_W = IDX_W + 1 + DATA_W;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    function automatic logic dst_none(input logic [DEST_W-1:0] d);
        return &d;
    endfunction
    function automatic logic dst_ext(input logic [DEST_W-1:0] d);
        return d[DEST_W-1] && !(&d);
    endfunction
    function automatic logic dst_int(input logic [DEST_W-1:0] d);
        return !d[DEST_W-1];
    endfunction

    dfs_state_e        state_q, state_d;
    logic [DATA_W-1:0] res_q;
    logic [DEST_W-1:0] d1_q, d2_q;
    logic              err_q;

    logic [TOK_W-1:0]  pend_dout, pend_din;
    logic [CNT_W-1:0]  pend_cnt;
    logic              pend_any, pend_push, pend_pop;

    logic [IDX_W-1:0]  cand_addr;
    logic              cand_port, cand_valid;
    logic [DATA_W-1:0] cand_data;

    dfs_op_e           rd_opc;
    logic [DEST_W-1:0] rd_d1, rd_d2;
    logic [DATA_W-1:0] rd_vl, rd_vr, alu_l, alu_r, alu_y;
    logic              rd_pl, rd_pr;
    logic              hit_full, other_full, would_fire, stall, can_go, take;
    logic [CNT_W:0]    need, room;

    logic [DEST_W-1:0] cur_dst;
    logic              advance;

    // candidate token: pending internal results take priority
    assign pend_any   = (pend_cnt != '0);
    assign cand_addr  = pend_any ? pend_dout[TOK_W-1 -: IDX_W] : in_addr;
    assign cand_port  = pend_any ? pend_dout[DATA_W] : in_port;
    assign cand_data  = pend_any ? pend_dout[DATA_W-1:0] : in_data;
    assign cand_valid = pend_any | in_valid;

    dfs_tpl_store #(
        .N_TPL(N_TPL), .IDX_W(IDX_W), .DATA_W(DATA_W), .DEST_W(DEST_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_we  (host_we),
        .host_addr(host_addr),
        .host_opc (dfs_op_e'(host_opc)),
        .host_d1  (host_dst1),
        .host_d2  (host_dst2),
        .set_we   (take && !hit_full && !other_full),
        .set_addr (cand_addr),
        .set_port (cand_port),
        .set_data (cand_data),
        .clr_we   (take && would_fire),
        .clr_addr (cand_addr),
        .rd_addr  (cand_addr),
        .rd_opc   (rd_opc),
        .rd_d1    (rd_d1),
        .rd_d2    (rd_d2),
        .rd_vl    (rd_vl),
        .rd_vr    (rd_vr),
        .rd_pl    (rd_pl),
        .rd_pr    (rd_pr)
    );

    assign hit_full   = cand_port ? rd_pr : rd_pl;
    assign other_full = cand_port ? rd_pl : rd_pr;
    assign would_fire = !hit_full && other_full;

    assign alu_l = cand_port ? rd_vl : cand_data;
    assign alu_r = cand_port ? cand_data : rd_vr;

    dfs_alu #(.DATA_W(DATA_W), .MUL_K(MUL_K)) u_alu (
        .opc(rd_opc), .lhs(alu_l), .rhs(alu_r), .res(alu_y)
    );

    // a firing may only start if its internal results fit in the queue
    assign need  = (CNT_W+1)'(dst_int(rd_d1)) + (CNT_W+1)'(dst_int(rd_d2));
    assign room  = (CNT_W+1)'(FIFO_DEPTH) - {1'b0, pend_cnt} + (CNT_W+1)'(pend_any);
    assign stall = would_fire && (need > room);

    assign can_go   = (state_q == ST_IDLE) && !host_we && !stall;
    assign take     = can_go && cand_valid;
    assign in_ready = can_go && !pend_any;
    assign pend_pop = take && pend_any;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // firing capture and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            d1_q  <= '1;
            d2_q  <= '1;
            err_q <= 1'b0;
        end else begin
            err_q <= take && hit_full;
            if (take && would_fire) begin
                res_q <= alu_y;
                d1_q  <= rd_d1;
                d2_q  <= rd_d2;
            end
        end
    end

    // next state and delivery outputs
    always_comb begin
        state_d   = state_q;
        cur_dst   = (state_q == ST_EMIT1) ? d1_q : d2_q;
        out_valid = 1'b0;
        pend_push = 1'b0;
        advance   = dst_none(cur_dst) || dst_int(cur_dst) ||
                    (dst_ext(cur_dst) && out_ready);
        unique case (state_q)
            ST_IDLE: begin
                if (take && would_fire) state_d = ST_EMIT1;
            end
            ST_EMIT1, ST_EMIT2: begin
                out_valid = dst_ext(cur_dst);
                pend_push = dst_int(cur_dst);
                if (advance)
                    state_d = (state_q == ST_EMIT1) ? ST_EMIT2 : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pend_din = {cur_dst[IDX_W:1], cur_dst[0], res_q};
    assign out_data = res_q;
    assign err_ovf  = err_q;

    dfs_tok_fifo #(.DEPTH(FIFO_DEPTH), .W(TOK_W)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .push (pend_push),
        .din  (pend_din),
        .pop  (pend_pop),
        .dout (pend_dout),
        .count(pend_cnt)
    );
endmodule

// File: rtl/dfs_engine_chk.sv
module dfs_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              err_ovf,
    input logic              pend_any
);
    // R1: leaving reset, nothing is offered and no error is flagged
    a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !err_ovf));

    // R8: a stalled result holds its value
    a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R2: host load blocks input in its cycle
    a_r2_host_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> !in_ready);

    // R9: pending internal tokens go first
    a_r9_internal_first: assert property (@(posedge clk) disable iff (!rst_n)
        pend_any |-> !in_ready);

    // R10: no input while delivering outward
    a_r10_no_accept_emit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R4: an error pulse follows a taken token
    a_r4_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |-> ($past(in_valid && in_ready) || $past(pend_any)));
endmodule

bind dfs_tpl_engine dfs_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_we  (host_we),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .err_ovf  (err_ovf),
    .pend_any (pend_any)
);

// File: tb/sim_dfs_tpl_engine.sv
module sim_dfs_tpl_engine;
    localparam int DW = 16;
    localparam logic [4:0] NONE = 5'h1F;
    localparam logic [4:0] EXT  = 5'h10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_we = 0; logic [2:0] host_addr = 0; logic [1:0] host_opc = 0;
    logic [4:0] host_dst1 = NONE, host_dst2 = NONE;
    logic in_valid = 0, in_port = 0; logic [2:0] in_addr = 0; logic [DW-1:0] in_data = 0;
    logic in_ready, out_valid, err_ovf; logic out_ready = 1; logic [DW-1:0] out_data;

    always #5 clk = ~clk;

    dfs_tpl_engine u0 (.*);

    int n_chk = 0, n_fail = 0;
    typedef struct { int a; bit p; logic [DW-1:0] v; } tok_t;
    int m_opc [8]; logic [4:0] m_d1 [8], m_d2 [8];
    logic [DW-1:0] m_vl [8], m_vr [8]; bit m_pl [8], m_pr [8];
    logic [DW-1:0] exp_q [$], got_q [$];
    int exp_err = 0, got_err = 0;

    task automatic check(bit ok, string rq, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    always @(negedge clk) if (rst_n) begin
        if (out_valid && out_ready) got_q.push_back(out_data);
        if (err_ovf) got_err++;
    end

    function automatic logic [DW-1:0] calc(int opc, logic [DW-1:0] l, logic [DW-1:0] r);
        case (opc)
            0: return l + r;
            1: return l - r;
            2: return l * 16'd3;
            default: return l;
        endcase
    endfunction

    task automatic model_tok(tok_t t0);
        tok_t q [$];
        q.push_back(t0);
        while (q.size() > 0) begin
            tok_t t = q.pop_front();
            bit hit = t.p ? m_pr[t.a] : m_pl[t.a];
            bit oth = t.p ? m_pl[t.a] : m_pr[t.a];
            if (hit) exp_err++;
            else if (oth) begin
                logic [DW-1:0] l = t.p ? m_vl[t.a] : t.v;
                logic [DW-1:0] r = t.p ? t.v : m_vr[t.a];
                logic [DW-1:0] y = calc(m_opc[t.a], l, r);
                logic [4:0] ds [2];
                m_pl[t.a] = 0; m_pr[t.a] = 0;
                ds[0] = m_d1[t.a]; ds[1] = m_d2[t.a];
                for (int k = 0; k < 2; k++) begin
                    if (ds[k] == NONE) continue;
                    if (ds[k][4]) exp_q.push_back(y);
                    else begin
                        tok_t n; n.a = int'(ds[k][3:1]); n.p = ds[k][0]; n.v = y;
                        q.push_back(n);
                    end
                end
            end else if (t.p) begin m_pr[t.a] = 1; m_vr[t.a] = t.v; end
            else begin m_pl[t.a] = 1; m_vl[t.a] = t.v; end
        end
    endtask

    task automatic load(int a, int opc, logic [4:0] d1, logic [4:0] d2);
        @(posedge clk); #1;
        host_we = 1; host_addr = 3'(a); host_opc = 2'(opc); host_dst1 = d1; host_dst2 = d2;
        @(posedge clk); #1;
        host_we = 0;
        m_opc[a] = opc; m_d1[a] = d1; m_d2[a] = d2; m_pl[a] = 0; m_pr[a] = 0;
    endtask

    task automatic send(int a, bit p, logic [DW-1:0] v);
        tok_t t;
        @(posedge clk); #1;
        in_valid = 1; in_addr = 3'(a); in_port = p; in_data = v;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 0;
        t.a = a; t.p = p; t.v = v;
        model_tok(t);
    endtask

    task automatic flush(string rq);
        repeat (12) @(negedge clk);
        check(got_q.size() == exp_q.size(), {rq, " count"}, got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size())
            foreach (exp_q[i]) check(got_q[i] === exp_q[i], {rq, " value"}, got_q[i], exp_q[i]);
        check(got_err == exp_err, {rq, " overflow"}, got_err, exp_err);
        got_q.delete(); exp_q.delete(); got_err = 0; exp_err = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_opc[i] = 0; m_d1[i] = NONE; m_d2[i] = NONE;
            m_vl[i] = 0; m_vr[i] = 0; m_pl[i] = 0; m_pr[i] = 0;
        end
        repeat (3) @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        check(!out_valid && !err_ovf, "R1 outputs idle", {out_valid, err_ovf}, 0);
        check(in_ready, "R1 ready", in_ready, 1);

        // R3, R5 add
        load(0, 0, EXT, NONE);
        send(0, 0, 16'd5);
        flush("R3 single operand");
        send(0, 1, 16'd9);
        flush("R5 add");
        // R5 presence cleared after firing
        send(0, 1, 16'd1);
        flush("R5 cleared after fire");
        send(0, 0, 16'd2);
        flush("R5 refire");
        // R5, R7 subtract wrap, two external tokens (R6 external code 0x1E)
        load(1, 1, EXT, 5'h1E);
        send(1, 0, 16'd3); send(1, 1, 16'd5);
        flush("R7 two outputs sub wrap");
        // R5 multiply and pass
        load(2, 2, EXT, NONE);
        send(2, 1, 16'd100); send(2, 0, 16'h6000);
        flush("R5 mulk");
        load(3, 3, NONE, EXT);
        send(3, 0, 16'd77); send(3, 1, 16'd1);
        flush("R5 pass");
        // R7 both none
        load(6, 0, NONE, NONE);
        send(6, 0, 16'd1); send(6, 1, 16'd1);
        flush("R7 no destination");
        // R4 overflow keeps stored value
        load(2, 0, EXT, NONE);
        send(2, 0, 16'd10); send(2, 0, 16'd20); send(2, 1, 16'd1);
        flush("R4 overflow drop");
        // R2 host load empties slots
        load(3, 0, EXT, NONE);
        send(3, 0, 16'd4);
        load(3, 0, EXT, NONE);
        send(3, 1, 16'd8);
        flush("R2 slots emptied");
        send(3, 0, 16'd6);
        flush("R2 new operand");
        // R9, R6 chain: t4 -> t5 L and t5 R, t5 -> external
        load(4, 0, 5'b0_101_0, 5'b0_101_1);
        load(5, 0, EXT, NONE);
        send(4, 0, 16'd2); send(4, 1, 16'd3);
        flush("R9 internal chain");
        // R4 via internal token: t5 L prefilled, t4 feeds t5 L twice
        load(4, 3, 5'b0_101_0, 5'b0_101_0);
        send(5, 0, 16'd1);
        send(4, 0, 16'd9); send(4, 1, 16'd0);
        flush("R4 internal overflow");
        send(5, 1, 16'd2);
        flush("R9 chain completion");
        // R8, R10 backpressure
        load(0, 0, EXT, NONE);
        send(0, 0, 16'd40);
        out_ready = 0;
        send(0, 1, 16'd2);
        repeat (2) @(negedge clk);
        check(out_valid && out_data == 16'd42, "R8 offered", out_data, 42);
        repeat (3) @(negedge clk);
        check(out_valid && out_data == 16'd42, "R8 held", out_data, 42);
        check(!in_ready, "R10 busy while emitting", in_ready, 0);
        @(posedge clk); #1 out_ready = 1;
        flush("R8 released");
        // R2 / R10 host write blocks input
        @(posedge clk); #1;
        host_we = 1; host_addr = 3'd7; host_opc = 0; host_dst1 = NONE; host_dst2 = NONE;
        in_valid = 1; in_addr = 3'd0; in_port = 0; in_data = 16'd1;
        @(negedge clk);
        check(!in_ready, "R2 ready low on host write", in_ready, 0);
        @(posedge clk); #1 host_we = 0; in_valid = 0;
        m_opc[7] = 0; m_d1[7] = NONE; m_d2[7] = NONE; m_pl[7] = 0; m_pr[7] = 0;

        // random: external or none destinations only
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++)
            load(i, int'($urandom_range(0, 3)),
                 ($urandom_range(0, 3) != 0) ? (EXT | 5'($urandom_range(0, 14))) : NONE,
                 ($urandom_range(0, 1) != 0) ? (EXT | 5'($urandom_range(0, 14))) : NONE);
        for (int n = 0; n < 300; n++) begin
            send(int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 16'($urandom));
            if (n % 10 == 9) flush("R5 R4 R7 random");
        end
        flush("R5 R4 R7 random end");
        finish_run();
    end
endmodule